// File: doc/BRIEF.md
# GPIO Pad Control Bank

This block controls a small bank of general-purpose port pins. Software reaches it through a single-cycle register write strobe and a combinational read strobe. Each pin holds six control bits: a GPIO function select, an input enable, an output enable, a pull enable, a pull direction and an output value. From these bits the block drives the pad-side signals: output value, driver enable, input buffer enable, pull-up enable and pull-down enable. The pin level is brought back through a two-flop synchroniser and can be read from a read-only data register.

Each pin has its own small state machine that holds the pad mode. The state is registered, so the pad signals change one clock after the control register that causes the change. The states are `ST_INIT` (function deselected, all pad controls off), `ST_FLOAT` (no driver, no pull), `ST_PULL_UP`, `ST_PULL_DN`, `ST_DRIVE_LO` and `ST_DRIVE_HI`. Every state can move to any other in one cycle.

The next state is decided by a fixed priority, checked in this order:
- Function select at 0 → `ST_INIT`.
- Output enable at 1 → `ST_DRIVE_HI` or `ST_DRIVE_LO`, chosen by the output value.
- Pull enable at 1 → `ST_PULL_UP` or `ST_PULL_DN`, chosen by the pull direction.
- Otherwise → `ST_FLOAT`.

Pins that the `GPIO_MASK` parameter marks as having no GPIO function can never be selected. They stay in `ST_INIT` for good.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After the synchronous active-low reset, every register reads 0, and `pad_oe`, `pad_out`, `pad_pu`, `pad_pd` and `pad_ie` are all 0.
- R2: For a selected pin with output enable 1, `pad_oe` is 1 and `pad_out` equals the output value bit. Pad signals take effect one clock after the register write lands, not on the same cycle.
- R3: While a pin's output enable is 1, `pad_pu` and `pad_pd` are both 0, whatever the pull bits hold.
- R4: For a selected pin with output enable 0 and pull enable 0, `pad_oe`, `pad_out`, `pad_pu` and `pad_pd` are 0. This holds whatever the input enable is. `pad_out` is 0 whenever `pad_oe` is 0.
- R5: For a selected pin with output enable 0 and pull enable 1, pull direction 1 gives `pad_pu`=1 and 0 gives `pad_pd`=1. The two are never 1 together.
- R6: `pad_ie` follows the input enable one clock after the register. The input data register (address 6) shows `pad_in` two clocks after it changes, and reads 0 for every pin whose input enable is 0.
- R7: While a pin's function select is 0, its control bits read 0 and writes to them are ignored. Clearing the select returns the pin to the reset pad state one clock later.
- R8: A pin whose `GPIO_MASK` bit is 0 has a function select that always reads 0, and its pad outputs stay 0.
- R9: Register map on `addr`, one bit per pin at bit position = pin index:
  - 0: function select
  - 1: input enable
  - 2: output enable
  - 3: pull enable
  - 4: pull direction
  - 5: output value
  - 6: input data (read-only)
  - 7: reads 0
  
  `rdata` is 0 when `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | NUM_PINS | Write data, one bit per pin |
| rdata | output | NUM_PINS | Read data, combinational |
| pad_in | input | NUM_PINS | Pin levels from the pads |
| pad_out | output | NUM_PINS | Output value to the pads |
| pad_oe | output | NUM_PINS | Output driver enable |
| pad_ie | output | NUM_PINS | Input buffer enable |
| pad_pu | output | NUM_PINS | Pull-up enable |
| pad_pd | output | NUM_PINS | Pull-down enable |

## Verification
The bench builds the bank with `NUM_PINS`=4 and `GPIO_MASK`=4'b0111. Because three pins can be selected and the fourth never can, a single vector can put several pins into different pad states at the same time. The same vector also checks that the pin without a GPIO function ignores every write, selection included. Four pins keep the vector table short, yet there is still room for a mix of selected and deselected pins when the select register is rewritten between vectors.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_FSEL = 3'd0;
    localparam logic [ADDR_W-1:0] A_IE   = 3'd1;
    localparam logic [ADDR_W-1:0] A_OE   = 3'd2;
    localparam logic [ADDR_W-1:0] A_PE   = 3'd3;
    localparam logic [ADDR_W-1:0] A_PDIR = 3'd4;
    localparam logic [ADDR_W-1:0] A_DOUT = 3'd5;
    localparam logic [ADDR_W-1:0] A_DIN  = 3'd6;

    typedef enum logic [2:0] {
        ST_INIT     = 3'd0,
        ST_FLOAT    = 3'd1,
        ST_PULL_UP  = 3'd2,
        ST_PULL_DN  = 3'd3,
        ST_DRIVE_LO = 3'd4,
        ST_DRIVE_HI = 3'd5
    } pin_state_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int              NUM_PINS  = 8,
    parameter logic [NUM_PINS-1:0] GPIO_MASK = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] fsel_q,
    output logic [NUM_PINS-1:0] ie_q,
    output logic [NUM_PINS-1:0] oe_q,
    output logic [NUM_PINS-1:0] pe_q,
    output logic [NUM_PINS-1:0] pdir_q,
    output logic [NUM_PINS-1:0] dout_q
);
    // Control bits of a deselected pin are held at zero; writes land only on selected pins.
    function automatic logic [NUM_PINS-1:0] upd(
        input logic [NUM_PINS-1:0] cur,
        input logic                hit,
        input logic [NUM_PINS-1:0] nv,
        input logic [NUM_PINS-1:0] sel
    );
        return (hit ? nv : cur) & sel;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsel_q <= '0;
            ie_q   <= '0;
            oe_q   <= '0;
            pe_q   <= '0;
            pdir_q <= '0;
            dout_q <= '0;
        end else begin
            if (wr_en && addr == A_FSEL)
                fsel_q <= wdata & GPIO_MASK;
            ie_q   <= upd(ie_q,   wr_en && addr == A_IE,   wdata, fsel_q);
            oe_q   <= upd(oe_q,   wr_en && addr == A_OE,   wdata, fsel_q);
            pe_q   <= upd(pe_q,   wr_en && addr == A_PE,   wdata, fsel_q);
            pdir_q <= upd(pdir_q, wr_en && addr == A_PDIR, wdata, fsel_q);
            dout_q <= upd(dout_q, wr_en && addr == A_DOUT, wdata, fsel_q);
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_PINS = 8,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] ie_en,
    output logic [NUM_PINS-1:0] din
);
    logic [NUM_PINS-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= pad_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign din = stage_q[STAGES-1] & ie_en;
endmodule

// File: rtl/gpio_pin_fsm.sv
module gpio_pin_fsm
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fsel,
    input  logic ie,
    input  logic oe,
    input  logic pe,
    input  logic pdir,
    input  logic dout,
    output logic pad_out,
    output logic pad_oe,
    output logic pad_ie,
    output logic pad_pu,
    output logic pad_pd
);
    pin_state_e state_q, state_d;
    logic       ie_q;

    always_comb begin
        if (!fsel)    state_d = ST_INIT;
        else if (oe)  state_d = dout ? ST_DRIVE_HI : ST_DRIVE_LO;
        else if (pe)  state_d = pdir ? ST_PULL_UP : ST_PULL_DN;
        else          state_d = ST_FLOAT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            ie_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ie_q    <= fsel & ie;
        end
    end

    always_comb begin
        pad_out = 1'b0;
        pad_oe  = 1'b0;
        pad_pu  = 1'b0;
        pad_pd  = 1'b0;
        pad_ie  = ie_q && (state_q != ST_INIT);
        unique case (state_q)
            ST_INIT:     ;
            ST_FLOAT:    ;
            ST_PULL_UP:  pad_pu = 1'b1;
            ST_PULL_DN:  pad_pd = 1'b1;
            ST_DRIVE_LO: pad_oe = 1'b1;
            ST_DRIVE_HI: begin
                pad_oe  = 1'b1;
                pad_out = 1'b1;
            end
            default:     pad_ie = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pkg::*;
#(
    parameter int                  NUM_PINS  = 8,
    parameter logic [NUM_PINS-1:0] GPIO_MASK = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [2:0]          addr,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_ie,
    output logic [NUM_PINS-1:0] pad_pu,
    output logic [NUM_PINS-1:0] pad_pd
);
    logic [NUM_PINS-1:0] fsel_q, ie_q, oe_q, pe_q, pdir_q, dout_q, din;

    gpio_regs #(.NUM_PINS(NUM_PINS), .GPIO_MASK(GPIO_MASK)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .fsel_q (fsel_q),
        .ie_q   (ie_q),
        .oe_q   (oe_q),
        .pe_q   (pe_q),
        .pdir_q (pdir_q),
        .dout_q (dout_q)
    );

    gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .ie_en  (ie_q),
        .din    (din)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_pin_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .fsel    (fsel_q[p]),
            .ie      (ie_q[p]),
            .oe      (oe_q[p]),
            .pe      (pe_q[p]),
            .pdir    (pdir_q[p]),
            .dout    (dout_q[p]),
            .pad_out (pad_out[p]),
            .pad_oe  (pad_oe[p]),
            .pad_ie  (pad_ie[p]),
            .pad_pu  (pad_pu[p]),
            .pad_pd  (pad_pd[p])
        );
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                A_FSEL:  rdata = fsel_q;
                A_IE:    rdata = ie_q   & fsel_q;
                A_OE:    rdata = oe_q   & fsel_q;
                A_PE:    rdata = pe_q   & fsel_q;
                A_PDIR:  rdata = pdir_q & fsel_q;
                A_DOUT:  rdata = dout_q & fsel_q;
                A_DIN:   rdata = din;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int                  NUM_PINS  = 8,
    parameter logic [NUM_PINS-1:0] GPIO_MASK = '1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en,
    input logic [2:0]          addr,
    input logic [NUM_PINS-1:0] rdata,
    input logic [NUM_PINS-1:0] fsel_q,
    input logic [NUM_PINS-1:0] ie_q,
    input logic [NUM_PINS-1:0] oe_q,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_ie,
    input logic [NUM_PINS-1:0] pad_pu,
    input logic [NUM_PINS-1:0] pad_pd
);
    p_oe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pad_oe == $past(oe_q & fsel_q));

    p_drive_no_pull_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & (pad_pu | pad_pd)) == '0);

    p_out_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    p_pull_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);

    p_din_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_DIN) |-> (rdata & ~ie_q) == '0);

    p_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pad_oe | pad_pu | pad_pd | pad_ie) & ~$past(fsel_q)) == '0);

    p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel_q & ~GPIO_MASK) == '0);
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.NUM_PINS(NUM_PINS), .GPIO_MASK(GPIO_MASK)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .addr    (addr),
    .rdata   (rdata),
    .fsel_q  (fsel_q),
    .ie_q    (ie_q),
    .oe_q    (oe_q),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pad_ie  (pad_ie),
    .pad_pu  (pad_pu),
    .pad_pd  (pad_pd)
);

// File: tb/gpio_pad_ctrl_tb.sv
module gpio_pad_ctrl_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          N          = 4;
    localparam logic [N-1:0] MASK      = 4'b0111;
    localparam int          NVEC       = 5;

    // {fsel, ie, oe, pe, pdir, dout, exp_oe, exp_out, exp_pu, exp_pd, exp_ie}
    localparam logic [43:0] VEC [NVEC] = '{
        {4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'h5, 4'h7, 4'h5, 4'h0, 4'h0, 4'h7},
        {4'h7, 4'h0, 4'h0, 4'h7, 4'h5, 4'h0, 4'h0, 4'h0, 4'h5, 4'h2, 4'h0},
        {4'h7, 4'h3, 4'h1, 4'h6, 4'h2, 4'hF, 4'h1, 4'h1, 4'h2, 4'h4, 4'h3},
        {4'h5, 4'hF, 4'h2, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'h5, 4'h0, 4'h5},
        {4'h0, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, pad_ie, pad_pu, pad_pd;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pad_ctrl #(.NUM_PINS(N), .GPIO_MASK(MASK)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_ie(pad_ie), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    task automatic chk(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [N-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [N-1:0] d);
        rd_en = 1'b1; addr = a;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N-1:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            reg_read(3'(a), v);
            chk("R1", "reg after reset", v, '0);
        end
        chk("R1", "pad_oe", pad_oe, '0);
        chk("R1", "pad_out", pad_out, '0);
        chk("R1", "pad_pu", pad_pu, '0);
        chk("R1", "pad_pd", pad_pd, '0);
        chk("R1", "pad_ie", pad_ie, '0);

        // Vector table: R2 R3 R4 R5 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            logic [N-1:0] f;
            f = VEC[i][43:40] & MASK;
            reg_write(3'd0, VEC[i][43:40]);
            reg_write(3'd1, VEC[i][39:36]);
            reg_write(3'd2, VEC[i][35:32]);
            reg_write(3'd3, VEC[i][31:28]);
            reg_write(3'd4, VEC[i][27:24]);
            reg_write(3'd5, VEC[i][23:20]);
            step();
            chk("R2", "pad_oe", pad_oe, VEC[i][19:16]);
            chk("R2", "pad_out", pad_out, VEC[i][15:12]);
            chk("R5", "pad_pu", pad_pu, VEC[i][11:8]);
            chk("R5", "pad_pd", pad_pd, VEC[i][7:4]);
            chk("R6", "pad_ie", pad_ie, VEC[i][3:0]);
            reg_read(3'd0, v); chk("R8", "fsel readback", v, f);
            reg_read(3'd2, v); chk("R9", "oe readback", v, VEC[i][35:32] & f);
            reg_read(3'd4, v); chk("R9", "pdir readback", v, VEC[i][27:24] & f);
        end

        // R6 input path latency and gating
        reg_write(3'd0, 4'b0001);
        reg_write(3'd1, 4'b0001);
        pad_in = 4'b0011;
        reg_read(3'd6, v); chk("R6", "din before sync", v, 4'b0000);
        step();
        reg_read(3'd6, v); chk("R6", "din after one clock", v, 4'b0000);
        step();
        reg_read(3'd6, v); chk("R6", "din after two clocks", v, 4'b0001);

        // R7 writes to deselected pins ignored, deselect returns initial state
        reg_write(3'd2, 4'b0110);
        reg_read(3'd2, v); chk("R7", "oe on deselected pins", v, 4'b0000);
        step();
        chk("R7", "pad_oe deselected", pad_oe, 4'b0000);
        reg_write(3'd0, 4'b0000);
        reg_read(3'd1, v); chk("R7", "ie after deselect", v, 4'b0000);
        step();
        chk("R7", "pad_ie after deselect", pad_ie, 4'b0000);
        reg_read(3'd6, v); chk("R6", "din with ie off", v, 4'b0000);

        // R2 one-clock lag from register to pad
        reg_write(3'd0, 4'b0001);
        reg_write(3'd2, 4'b0001);
        reg_write(3'd5, 4'b0000);
        step();
        chk("R2", "drive low oe", pad_oe, 4'b0001);
        chk("R2", "drive low out", pad_out, 4'b0000);
        reg_write(3'd5, 4'b0001);
        chk("R2", "out before lag", pad_out, 4'b0000);
        step();
        chk("R2", "out after lag", pad_out, 4'b0001);
        reg_write(3'd3, 4'b0001);
        reg_write(3'd4, 4'b0001);
        step();
        chk("R3", "no pull while driving", pad_pu | pad_pd, 4'b0000);
        reg_write(3'd2, 4'b0000);
        step();
        chk("R5", "pull-up after oe off", pad_pu, 4'b0001);
        chk("R4", "out idle when not driving", pad_out, 4'b0000);

        // R8 masked pin
        reg_write(3'd0, 4'b1111);
        reg_read(3'd0, v); chk("R8", "fsel masked", v, 4'b0111);
        reg_write(3'd2, 4'b1000);
        step();
        chk("R8", "masked pin pad_oe", pad_oe & 4'b1000, 4'b0000);

        // R9 unmapped address and rd_en low
        reg_read(3'd7, v); chk("R9", "unmapped addr", v, 4'b0000);
        addr = 3'd0; #1;
        chk("R9", "rdata with rd_en low", rdata, 4'b0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule